// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits beside the page loader of a byte-wide non-volatile memory. It watches each byte write command, which carries a 17-bit address and an 8-bit data value. It keeps one protect bit that decides whether writes may reach the array. For every write it gives a verdict in the same cycle, as one of three results:
- the byte is stored;
- the byte is discarded, and the loader still starts its programming timer for a full write period;
- the byte is consumed as a key byte and is neither stored nor discarded.

Two keyed codes control the protect bit. A three-byte code arms a write session and, at the end of that write period, leaves protection on. When protection is already on, the same code serves as the per-period unlock. A six-byte code arms a session that turns protection off at the end of its period. In both cases the data bytes that follow the code in the same period are stored. A code takes effect at period end even when no data bytes follow it.

The protect bit loads a parameter value only on reset, so a model that keeps the register across power cycles keeps the state. A mismatching byte aborts a partial code. The end of a write period also drops any partial code.

Top module: `swp_seq`

## Requirements
- R1: After reset `prot_o` equals parameter `PROT_INIT` (default 0), and no verdict or update output is high. With `PROT_INIT`=1, a plain write right after reset is discarded.
- R2: When protection is off and no code is in progress, a plain write gives `wr_allow_o`=1, `wr_discard_o`=0 and `wr_key_o`=0 in the same cycle. All three verdict outputs are 0 in any cycle without `wr_valid_i`.
- R3: When protection is on and no session is armed, a plain write gives `wr_discard_o`=1, `wr_allow_o`=0 and `wr_key_o`=0.
- R4: The enable code is the three writes (address 0x05555, data 0xAA), (0x02AAA, 0x55), (0x05555, 0xA0), in that order. Each of these bytes gives `wr_key_o`=1 with allow and discard at 0. Later writes in the same period give `wr_allow_o`=1. In the `period_end_i` cycle, `prot_upd_o`=1 and `prot_new_o`=1, and `prot_o` is 1 from the next cycle.
- R5: The disable code is the six writes 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x20@0x05555, each giving `wr_key_o`=1. Later writes in that period are allowed. At period end `prot_upd_o`=1 with `prot_new_o`=0, and `prot_o` is 0 from the next cycle.
- R6: A completed code with no data bytes after it still changes `prot_o` at the end of its period.
- R7: `prot_o` changes only in the cycle after a `prot_upd_o` pulse. A period end with no completed code gives no pulse.
- R8: A byte that does not match the next code step aborts the partial code and is judged as a plain write (R2 or R3). If that byte is 0xAA@0x05555, it is taken as the first step of a new code and gives `wr_key_o`=1.
- R9: An armed session lasts one period. After the period end, protected plain writes are discarded again.
- R10: `period_end_i` drops a partial code. A following 0x55@0x02AAA is then a plain write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One byte write command this cycle |
| wr_addr_i | input | 17 | Write address |
| wr_data_i | input | 8 | Write data |
| period_end_i | input | 1 | Current write period ends this cycle |
| wr_allow_o | output | 1 | Store this byte |
| wr_discard_o | output | 1 | Drop this byte, still run the write timer |
| wr_key_o | output | 1 | Byte consumed as a key step |
| prot_upd_o | output | 1 | Protect state updates at this period end |
| prot_new_o | output | 1 | New protect value, valid with `prot_upd_o` |
| prot_o | output | 1 | Current protect state |

## Verification
The hardest case to reach from the ports is an abort that lands on a byte that is itself a valid first step. To get there, the stimulus first drives protection on, then sends two 0xAA@0x05555 bytes back to back. The second must restart the code rather than be discarded, and the session that follows is unlocked. A partial code cut by a period end is reached the same way, with `period_end_i` driven between the first and second key bytes.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_SET  = 2'd1,
    PEND_CLR  = 2'd2
  } pend_e;

  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  // Steps 1 and 4 use the secondary key address, the rest the primary one.
  function automatic bit step_uses_alt_addr(input int unsigned idx);
    return (idx == 1) || (idx == 4);
  endfunction
endpackage

// File: rtl/swp_key_matcher.sv
module swp_key_matcher
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 17'h05555,
  parameter logic [ADDR_W-1:0] ADDR_B = 17'h02AAA,
  parameter logic [DATA_W-1:0] D_OPEN = 8'hAA,
  parameter logic [DATA_W-1:0] D_ACK  = 8'h55,
  parameter logic [DATA_W-1:0] D_ENA  = 8'hA0,
  parameter logic [DATA_W-1:0] D_MID  = 8'h80,
  parameter logic [DATA_W-1:0] D_LAST = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              listen_i,
  input  logic              clear_i,
  output logic              key_o,
  output logic              ena_done_o,
  output logic              dis_done_o
);
  localparam int unsigned SLOTS = 2**STEP_W;
  localparam logic [STEP_W-1:0] FORK_STEP = STEP_W'(2);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS-1);

  logic [STEP_W-1:0] step_q, step_d;
  logic [SLOTS-1:0]  step_hit;
  logic              ena_hit, key, ena, dis;

  for (genvar g = 0; g < SLOTS; g++) begin : g_step
    if (g < NUM_STEPS) begin : g_live
      localparam logic [ADDR_W-1:0] EXP_A = step_uses_alt_addr(g) ? ADDR_B : ADDR_A;
      localparam logic [DATA_W-1:0] EXP_D =
        step_uses_alt_addr(g) ? D_ACK :
        (g == 2)              ? D_MID :
        (g == 5)              ? D_LAST : D_OPEN;
      assign step_hit[g] = (addr_i == EXP_A) && (data_i == EXP_D);
    end else begin : g_pad
      assign step_hit[g] = 1'b0;
    end
  end

  assign ena_hit = (addr_i == ADDR_A) && (data_i == D_ENA);

  always_comb begin
    step_d = step_q;
    key    = 1'b0;
    ena    = 1'b0;
    dis    = 1'b0;
    if (valid_i && listen_i) begin
      if (step_q == FORK_STEP && ena_hit) begin
        key    = 1'b1;
        ena    = 1'b1;
        step_d = '0;
      end else if (step_hit[step_q]) begin
        key = 1'b1;
        if (step_q == LAST_STEP) begin
          dis    = 1'b1;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else if (step_hit[0]) begin
        // abort, but the breaking byte opens a fresh code
        key    = 1'b1;
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
    if (clear_i) step_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign key_o      = key;
  assign ena_done_o = ena & ~clear_i;
  assign dis_done_o = dis & ~clear_i;

  assert_step_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q < STEP_W'(NUM_STEPS));

  assert_key_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_o && !ena_done_o && !dis_done_o && !clear_i) |=> (step_q != '0));

  assert_clear_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (step_q == '0));
endmodule

// File: rtl/swp_prot_state.sv
module swp_prot_state
  import swp_pkg::*;
#(
  parameter bit PROT_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic key_i,
  input  logic ena_done_i,
  input  logic dis_done_i,
  input  logic period_end_i,
  output logic listen_o,
  output logic allow_o,
  output logic discard_o,
  output logic upd_o,
  output logic upd_val_o,
  output logic prot_o
);
  pend_e pend_q, pend_d;
  logic  prot_q;
  logic  armed;

  assign armed    = (pend_q != PEND_NONE);
  assign listen_o = ~armed;

  assign allow_o   = valid_i & ~key_i & (armed | ~prot_q);
  assign discard_o = valid_i & ~key_i & ~armed & prot_q;

  assign upd_o     = period_end_i & armed;
  assign upd_val_o = (pend_q == PEND_SET);

  always_comb begin
    pend_d = pend_q;
    if (period_end_i)    pend_d = PEND_NONE;
    else if (ena_done_i) pend_d = PEND_SET;
    else if (dis_done_i) pend_d = PEND_CLR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= PEND_NONE;
      prot_q <= PROT_INIT;
    end else begin
      pend_q <= pend_d;
      if (upd_o) prot_q <= upd_val_o;
    end
  end

  assign prot_o = prot_q;

  assert_verdict_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({allow_o, discard_o, key_i}));

  assert_discard_only_prot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> prot_o);

  assert_prot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |=> $stable(prot_o));

  assert_prot_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> (prot_o == $past(upd_val_o)));

  assert_session_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=> listen_o);
endmodule

// File: rtl/swp_seq.sv
module swp_seq #(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter bit          PROT_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              period_end_i,
  output logic              wr_allow_o,
  output logic              wr_discard_o,
  output logic              wr_key_o,
  output logic              prot_upd_o,
  output logic              prot_new_o,
  output logic              prot_o
);
  logic listen, key, ena_done, dis_done;

  swp_key_matcher #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ADDR_A (ADDR_W'(17'h05555)),
    .ADDR_B (ADDR_W'(17'h02AAA)),
    .D_OPEN (DATA_W'(8'hAA)),
    .D_ACK  (DATA_W'(8'h55)),
    .D_ENA  (DATA_W'(8'hA0)),
    .D_MID  (DATA_W'(8'h80)),
    .D_LAST (DATA_W'(8'h20))
  ) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (wr_valid_i),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .listen_i   (listen),
    .clear_i    (period_end_i),
    .key_o      (key),
    .ena_done_o (ena_done),
    .dis_done_o (dis_done)
  );

  swp_prot_state #(
    .PROT_INIT (PROT_INIT)
  ) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (wr_valid_i),
    .key_i        (key),
    .ena_done_i   (ena_done),
    .dis_done_i   (dis_done),
    .period_end_i (period_end_i),
    .listen_o     (listen),
    .allow_o      (wr_allow_o),
    .discard_o    (wr_discard_o),
    .upd_o        (prot_upd_o),
    .upd_val_o    (prot_new_o),
    .prot_o       (prot_o)
  );

  assign wr_key_o = key;

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> !(wr_allow_o || wr_discard_o || wr_key_o));

  assert_upd_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_upd_o |-> period_end_i);
endmodule

// File: tb/swp_seq_test.sv
`timescale 1ns/1ps
module swp_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        period_end = 1'b0;
  logic        allow, discard, key, upd, new_val, prot;
  logic        p_allow, p_discard, p_key, p_upd, p_new, p_prot;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [16:0] KA = 17'h05555;
  localparam logic [16:0] KB = 17'h02AAA;

  always #5 clk = ~clk;

  swp_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .period_end_i(period_end), .wr_allow_o(allow),
    .wr_discard_o(discard), .wr_key_o(key), .prot_upd_o(upd),
    .prot_new_o(new_val), .prot_o(prot)
  );

  swp_seq #(.PROT_INIT(1'b1)) uut_p (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .period_end_i(period_end), .wr_allow_o(p_allow),
    .wr_discard_o(p_discard), .wr_key_o(p_key), .prot_upd_o(p_upd),
    .prot_new_o(p_new), .prot_o(p_prot)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d,
                    input logic ea, input logic ed, input logic ek, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk(tag, "allow", allow, ea);
    chk(tag, "discard", discard, ed);
    chk(tag, "key", key, ek);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic end_period(input logic eu, input logic ev, input logic ep, input string tag);
    @(negedge clk);
    period_end = 1'b1;
    #1;
    chk(tag, "upd", upd, eu);
    if (eu) chk(tag, "new", new_val, ev);
    @(posedge clk); #1;
    period_end = 1'b0;
    chk(tag, "prot", prot, ep);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "prot", prot, 1'b0);
    chk("R1", "prot_init1", p_prot, 1'b1);
    chk("R1", "upd", upd, 1'b0);
    chk("R2", "idle_allow", allow, 1'b0);
    chk("R2", "idle_key", key, 1'b0);
    wr_valid = 1'b1; wr_addr = 17'h00100; wr_data = 8'h3C;
    #1;
    chk("R1", "init1_discard", p_discard, 1'b1);
    chk("R2", "plain_allow", allow, 1'b1);
    chk("R2", "plain_discard", discard, 1'b0);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    end_period(1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_enable();
    wr(KA, 8'hAA, 0, 0, 1, "R4");
    wr(KB, 8'h55, 0, 0, 1, "R4");
    wr(KA, 8'hA0, 0, 0, 1, "R4");
    wr(17'h00200, 8'h11, 1, 0, 0, "R4");
    end_period(1'b1, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_protected_plain();
    wr(17'h00300, 8'h22, 0, 1, 0, "R3");
    end_period(1'b0, 1'b0, 1'b1, "R7");
  endtask

  task automatic t_unlock_one_period();
    wr(KA, 8'hAA, 0, 0, 1, "R4");
    wr(KB, 8'h55, 0, 0, 1, "R4");
    wr(KA, 8'hA0, 0, 0, 1, "R4");
    wr(17'h00400, 8'h44, 1, 0, 0, "R9");
    end_period(1'b1, 1'b1, 1'b1, "R9");
    wr(17'h00401, 8'h45, 0, 1, 0, "R9");
    end_period(1'b0, 1'b0, 1'b1, "R9");
  endtask

  task automatic t_abort_protected();
    wr(KA, 8'hAA, 0, 0, 1, "R8");
    wr(KB, 8'h55, 0, 0, 1, "R8");
    wr(17'h00100, 8'h12, 0, 1, 0, "R8");
    wr(KA, 8'hAA, 0, 0, 1, "R8");
    wr(KA, 8'hAA, 0, 0, 1, "R8");
    wr(KB, 8'h55, 0, 0, 1, "R8");
    wr(KA, 8'hA0, 0, 0, 1, "R8");
    wr(17'h00500, 8'h66, 1, 0, 0, "R8");
    end_period(1'b1, 1'b1, 1'b1, "R8");
  endtask

  task automatic t_period_clears_partial();
    wr(KA, 8'hAA, 0, 0, 1, "R10");
    end_period(1'b0, 1'b0, 1'b1, "R10");
    wr(KB, 8'h55, 0, 1, 0, "R10");
    end_period(1'b0, 1'b0, 1'b1, "R10");
  endtask

  task automatic t_disable_no_data();
    wr(KA, 8'hAA, 0, 0, 1, "R5");
    wr(KB, 8'h55, 0, 0, 1, "R5");
    wr(KA, 8'h80, 0, 0, 1, "R5");
    wr(KA, 8'hAA, 0, 0, 1, "R5");
    wr(KB, 8'h55, 0, 0, 1, "R5");
    wr(KA, 8'h20, 0, 0, 1, "R5");
    end_period(1'b1, 1'b0, 1'b0, "R6");
    wr(17'h00600, 8'h77, 1, 0, 0, "R5");
    end_period(1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_abort_unprotected();
    wr(KA, 8'hAA, 0, 0, 1, "R8");
    wr(17'h00010, 8'h33, 1, 0, 0, "R8");
    end_period(1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_enable_then_disable_data();
    wr(KA, 8'hAA, 0, 0, 1, "R6");
    wr(KB, 8'h55, 0, 0, 1, "R6");
    wr(KA, 8'hA0, 0, 0, 1, "R6");
    end_period(1'b1, 1'b1, 1'b1, "R6");
    wr(KA, 8'hAA, 0, 0, 1, "R5");
    wr(KB, 8'h55, 0, 0, 1, "R5");
    wr(KA, 8'h80, 0, 0, 1, "R5");
    wr(KA, 8'hAA, 0, 0, 1, "R5");
    wr(KB, 8'h55, 0, 0, 1, "R5");
    wr(KA, 8'h20, 0, 0, 1, "R5");
    wr(17'h00700, 8'h88, 1, 0, 0, "R5");
    end_period(1'b1, 1'b0, 1'b0, "R5");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_enable();
    t_protected_plain();
    t_unlock_one_period();
    t_abort_protected();
    t_period_clears_partial();
    t_disable_no_data();
    t_abort_unprotected();
    t_enable_then_disable_data();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule